// File: doc/BRIEF.md
# Banked Integer Register File with Privileged Shadows

This block is a 64-bit integer register file with two read ports and one write port. Register indices are 5 bits wide. Indices 0 to 30 address real storage. Index 31 is a hardwired zero.

A second, small bank of eight shadow registers sits beside the main array. While the privileged-mode input is high, a fixed set of indices stops addressing the main array and addresses the shadow bank instead. Indices 8 to 14 go to shadow entries 0 to 6, and index 25 goes to shadow entry 7. The redirection applies equally to both read ports and to the write port.

Privileged code can therefore use those registers as scratch space without saving the interrupted context first. The hidden main-array values come back untouched as soon as the flag drops.

Reads are combinational from the stored state. A read issued in the same cycle as a write to the same location returns the value held before that write.

Top module: `shadow_regfile`

## Requirements
- R1: With the privileged flag low, every index 0 to 30 on any port addresses main-array entry of the same number.
- R2: With the privileged flag high, indices 8, 9, 10, 11, 12, 13 and 14 address shadow entries 0, 1, 2, 3, 4, 5 and 6 respectively.
- R3: With the privileged flag high, index 25 addresses shadow entry 7.
- R4: With the privileged flag high, every index other than 8 to 14, 25 and 31 still addresses the main array.
- R5: Index 31 reads as zero on both read ports in either mode, and a write to index 31 changes no register.
- R6: The same redirection is applied to read port A, read port B and the write port, so a value written under one mode is read back on either port under that mode.
- R7: Shadow contents persist while the flag is low, and main-array entries hidden by the shadows keep their contents while the flag is high.
- R8: A read of the location being written in the same cycle returns the old value; the new value is visible from the next cycle.
- R9: With the write enable low, no register changes, whatever the write index and data.
- R10: Reset clears every main-array entry and every shadow entry to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| privMode | input | 1 | High selects the shadow redirection |
| rdIdxA | input | 5 | Read port A register index |
| rdIdxB | input | 5 | Read port B register index |
| wrIdx | input | 5 | Write port register index |
| wrEn | input | 1 | Write enable |
| wrData | input | 64 | Write data |
| rdDataA | output | 64 | Read port A value |
| rdDataB | output | 64 | Read port B value |

## Verification
After reset, every index is swept on both ports in both modes. This shows the cleared state of both banks and tells a missed shadow entry apart from a missed main entry.

Directed writes then fill every main entry with distinct patterns while the flag is low, and fill the shadows while it is high. Reading those indices back under the opposite mode separates correct aliasing from a leak between banks.

Further directed cycles cover a write with the enable low, a write to index 31, and a read that collides with a write in the same cycle. A long random run follows, weighted toward indices 8 to 14 and 25. A behavioural model checks both read ports against it on every cycle.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int XLEN       = 64;
  localparam int REG_CNT    = 32;
  localparam int IDXW       = $clog2(REG_CNT);
  localparam int ZERO_IDX   = REG_CNT - 1;
  localparam int SHADOW_LO  = 8;
  localparam int SHADOW_HI  = 14;
  localparam int SHADOW_ALT = 25;
  localparam int SH_CNT     = SHADOW_HI - SHADOW_LO + 2;
  localparam int SHW        = $clog2(SH_CNT);
  localparam int RD_PORTS   = 2;

  // Resolved storage location for one index
  typedef struct packed {
    logic            isZero;
    logic            isShadow;
    logic [IDXW-1:0] mainIdx;
    logic [SHW-1:0]  shIdx;
  } loc_t;

  // Strobes from control to datapath
  typedef struct packed {
    loc_t rdA;
    loc_t rdB;
    loc_t wr;
    logic wrMainStb;
    logic wrShStb;
  } strobe_t;
endpackage

// File: rtl/srf_remap.sv
module srf_remap
  import srf_pkg::*;
(
  input  logic            privMode,
  input  logic [IDXW-1:0] idx,
  output loc_t            loc
);
  logic            inRange;
  logic            isAlt;
  logic [IDXW-1:0] offset;

  assign inRange = (idx >= IDXW'(SHADOW_LO)) && (idx <= IDXW'(SHADOW_HI));
  assign isAlt   = (idx == IDXW'(SHADOW_ALT));
  assign offset  = idx - IDXW'(SHADOW_LO);

  always_comb begin
    loc = '0;
    if (idx == IDXW'(ZERO_IDX)) begin
      loc.isZero = 1'b1;
    end else if (privMode && inRange) begin
      loc.isShadow = 1'b1;
      loc.shIdx    = offset[SHW-1:0];
    end else if (privMode && isAlt) begin
      loc.isShadow = 1'b1;
      loc.shIdx    = SHW'(SH_CNT - 1);
    end else begin
      loc.mainIdx = idx;
    end
  end
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
  import srf_pkg::*;
(
  input  logic            privMode,
  input  logic [IDXW-1:0] rdIdxA,
  input  logic [IDXW-1:0] rdIdxB,
  input  logic [IDXW-1:0] wrIdx,
  input  logic            wrEn,
  output strobe_t         stb
);
  localparam int N_MAP = RD_PORTS + 1;

  logic [IDXW-1:0] portIdx [N_MAP];
  loc_t            portLoc [N_MAP];

  assign portIdx[0] = rdIdxA;
  assign portIdx[1] = rdIdxB;
  assign portIdx[2] = wrIdx;

  for (genvar k = 0; k < N_MAP; k++) begin : g_map
    srf_remap u_map (
      .privMode (privMode),
      .idx      (portIdx[k]),
      .loc      (portLoc[k])
    );
  end

  always_comb begin
    stb           = '0;
    stb.rdA       = portLoc[0];
    stb.rdB       = portLoc[1];
    stb.wr        = portLoc[2];
    stb.wrMainStb = wrEn && !portLoc[2].isZero && !portLoc[2].isShadow;
    stb.wrShStb   = wrEn && portLoc[2].isShadow;
  end
endmodule

// File: rtl/srf_dpath.sv
module srf_dpath
  import srf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         stb,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB
);
  logic [XLEN-1:0] mainQ [REG_CNT];
  logic [XLEN-1:0] shQ   [SH_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < REG_CNT; r++) mainQ[r] <= '0;
    end else if (stb.wrMainStb) begin
      mainQ[stb.wr.mainIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SH_CNT; s++) shQ[s] <= '0;
    end else if (stb.wrShStb) begin
      shQ[stb.wr.shIdx] <= wrData;
    end
  end

  loc_t            rdLoc [RD_PORTS];
  logic [XLEN-1:0] rdVal [RD_PORTS];

  assign rdLoc[0] = stb.rdA;
  assign rdLoc[1] = stb.rdB;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_comb begin
      if (rdLoc[p].isZero)        rdVal[p] = '0;
      else if (rdLoc[p].isShadow) rdVal[p] = shQ[rdLoc[p].shIdx];
      else                        rdVal[p] = mainQ[rdLoc[p].mainIdx];
    end
  end

  assign rdDataA = rdVal[0];
  assign rdDataB = rdVal[1];

  // R1
  main_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && stb.wrMainStb) |=> (mainQ[$past(stb.wr.mainIdx)] == $past(wrData)));

  // R2
  shadow_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && stb.wrShStb) |=> (shQ[$past(stb.wr.shIdx)] == $past(wrData)));

  // R5
  zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mainQ[ZERO_IDX] == '0);
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import srf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            privMode,
  input  logic [IDXW-1:0] rdIdxA,
  input  logic [IDXW-1:0] rdIdxB,
  input  logic [IDXW-1:0] wrIdx,
  input  logic            wrEn,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB
);
  strobe_t stb;

  srf_ctrl u_ctrl (
    .privMode (privMode),
    .rdIdxA   (rdIdxA),
    .rdIdxB   (rdIdxB),
    .wrIdx    (wrIdx),
    .wrEn     (wrEn),
    .stb      (stb)
  );

  srf_dpath u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .wrData  (wrData),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

  // R5
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdxA == IDXW'(ZERO_IDX)) |-> (rdDataA == '0));

  // R1
  plain_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !privMode |-> (!stb.wrShStb && !stb.rdA.isShadow && !stb.rdB.isShadow));

  // R9
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> (!stb.wrShStb && !stb.wrMainStb));
endmodule

// File: tb/shadow_regfile_tb_top.sv
module shadow_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        privMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdDataA, rdDataB;

  int vecCnt = 0;
  int badCnt = 0;
  bit done = 1'b0;

  logic [63:0] refMain [32];
  logic [63:0] refSh   [8];

  always #4 clk = ~clk;

  shadow_regfile dut_i (
    .clk (clk), .rst_n (rst_n), .privMode (privMode),
    .rdIdxA (rdIdxA), .rdIdxB (rdIdxB), .wrIdx (wrIdx),
    .wrEn (wrEn), .wrData (wrData),
    .rdDataA (rdDataA), .rdDataB (rdDataB)
  );

  function automatic int locOf(bit p, int idx);
    if (idx == 31) return -1;
    if (p && idx >= 8 && idx <= 14) return 100 + idx - 8;
    if (p && idx == 25) return 107;
    return idx;
  endfunction

  function automatic logic [63:0] refRead(bit p, int idx);
    int l = locOf(p, idx);
    if (l < 0) return 64'd0;
    if (l >= 100) return refSh[l-100];
    return refMain[l];
  endfunction

  function automatic string autoTag(bit p, int ri, bit we, int wi);
    if (we && wi != 31 && locOf(p, ri) == locOf(p, wi)) return "R8";
    if (ri == 31) return "R5";
    if (p && ri >= 8 && ri <= 14) return "R2";
    if (p && ri == 25) return "R3";
    if (p) return "R4";
    return "R1";
  endfunction

  task automatic compare(string tag, string port, logic [63:0] act, logic [63:0] exp);
    vecCnt++;
    if (act !== exp) begin
      badCnt++;
      $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic step(bit p, int ra, int rb, int wi, logic [63:0] wd, bit we, string tag = "");
    int l;
    @(negedge clk);
    privMode = p; rdIdxA = 5'(ra); rdIdxB = 5'(rb);
    wrIdx = 5'(wi); wrData = wd; wrEn = we;
    #1;
    compare((tag == "") ? autoTag(p, ra, we, wi) : tag, "A", rdDataA, refRead(p, ra));
    compare((tag == "") ? autoTag(p, rb, we, wi) : tag, "B", rdDataB, refRead(p, rb));
    @(posedge clk);
    if (we) begin
      l = locOf(p, wi);
      if (l >= 100) refSh[l-100] = wd;
      else if (l >= 0) refMain[l] = wd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      badCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) refMain[i] = '0;
    for (int i = 0; i < 8; i++) refSh[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: everything reads zero after reset, both modes
    for (int i = 0; i < 32; i++) step(0, i, 31 - i, 0, 64'h0, 0, "R10");
    for (int i = 0; i < 32; i++) step(1, i, 31 - i, 0, 64'h0, 0, "R10");

    // R1: fill main array with distinct patterns, flag low
    for (int i = 0; i < 32; i++)
      step(0, i, (i + 1) % 32, i, {32'hA5A50000 + 32'(i), 32'(i * 7919)}, 1);
    for (int i = 0; i < 32; i++) step(0, i, 31 - i, 0, 64'h0, 0);

    // R2 R3 R4: shadows still zero under privilege, others main
    for (int i = 0; i < 32; i++) step(1, i, 31 - i, 0, 64'h0, 0);

    // R2 R3: fill shadows, R5 write to 31 discarded
    for (int i = 8; i <= 14; i++) step(1, i, 25, i, {32'h5EED0000 + 32'(i), 32'hC0FFEE00}, 1);
    step(1, 25, 8, 25, 64'h2525_2525_DEAD_BEEF, 1);
    step(1, 31, 31, 31, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R5");
    step(1, 31, 30, 0, 64'h0, 0, "R5");
    step(0, 31, 31, 0, 64'h0, 0, "R5");

    // R7: hidden main entries intact, then shadows intact
    for (int i = 8; i <= 14; i++) step(0, i, 25, 0, 64'h0, 0, "R7");
    for (int i = 8; i <= 14; i++) step(1, i, 25, 0, 64'h0, 0, "R7");

    // R9: write with enable low changes nothing
    step(0, 5, 12, 5, 64'h1234_5678_9ABC_DEF0, 0, "R9");
    step(0, 5, 12, 12, 64'h0BAD_0BAD_0BAD_0BAD, 0, "R9");
    step(1, 12, 5, 12, 64'h0BAD_0BAD_0BAD_0BAD, 0, "R9");

    // R6: write under each mode, read on both ports
    step(1, 0, 0, 12, 64'h6666_0000_1111_2222, 1);
    step(1, 12, 12, 0, 64'h0, 0, "R6");
    step(0, 12, 12, 12, 64'h7777_0000_3333_4444, 1);
    step(0, 12, 12, 0, 64'h0, 0, "R6");
    step(1, 12, 12, 0, 64'h0, 0, "R6");

    // R8: same-cycle read of written location returns old value
    step(1, 25, 25, 25, 64'h8888_8888_0000_0001, 1, "R8");
    step(1, 25, 25, 0, 64'h0, 0, "R8");
    step(0, 3, 3, 3, 64'h8888_8888_0000_0003, 1, "R8");
    step(0, 3, 3, 0, 64'h0, 0, "R8");

    // Random mix weighted toward redirected indices
    for (int n = 0; n < 3000; n++) begin
      int idx [3];
      for (int k = 0; k < 3; k++) begin
        case ($urandom % 4)
          0: idx[k] = 8 + int'($urandom % 7);
          1: idx[k] = 25;
          default: idx[k] = int'($urandom % 32);
        endcase
      end
      step(bit'($urandom % 2), idx[0], idx[1], idx[2],
           {$urandom, $urandom}, ($urandom % 10) < 7);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end
endmodule